// File: doc/BRIEF.md
# Register-Triggered Transmit Sync Router

This block turns bits that software writes into a trigger register into one-cycle sync pulses for five transmit sub-blocks: the FIFO, the coarse mixer, the clock divider, the offset corrector and the gain/phase corrector. The block stores the last value written. A bit that goes from 0 to 1 on a write is a sync event. Each event is steered to the targets by a routing configuration.

Two routing regimes exist. When the global sync disable is clear, one shared path feeds every target at once. The shared path's source is either the global trigger bit or one of the external sync inputs, chosen by a 2-bit select. When the global sync disable is set, each target has its own path. Each target's path is gated by that target's own disable and fed either by its own trigger bit or by the external sync input that its select names. The outputs are registered, so a qualifying event appears as a pulse in the cycle after the write edge.

Top module: `txsync_router`

## Requirements
- R1: After reset, the trigger register holds all zeros and every sync output is low. A first write of a 1 therefore counts as a rising event.
- R2: A sync event needs a write (`wr_en` high) that takes a trigger bit from 0 to 1. Rewriting a 1, clearing a bit, or changing `wr_data` without `wr_en` produces no pulse.
- R3: Trigger bits map to targets as follows: bit 0 FIFO, bit 1 mixer, bit 2 divider, bit 3 offset correction, bit 4 gain/phase correction, bit 5 global. Output `sync_pulse[i]` serves the target of trigger bit `i` for i = 0..4.
- R4: A per-target trigger bit (bits 0..4) drives its target only when all three hold: `glb_dis` = 1, the target's `tgt_dis` bit = 0, and the target's select field = 0 (the serial trigger code).
- R5: The global trigger bit (bit 5) has an effect only when `glb_dis` = 0 and `glb_sel` = 0. Its event pulses all five outputs in the same cycle. While `glb_dis` = 0, all five outputs are always equal.
- R6: Each sync output is high for exactly one clock, in the cycle after the clock edge that samples the qualifying write or external pulse. With no write and no external pulse, all outputs are low in the next cycle.
- R7: A select value k in 1..3 (per-target field `tgt_sel[2t+1:2t]`, or `glb_sel`) routes `ext_sync[k-1]` in place of the trigger bit. The path's own disable conditions still gate it.
- R8: When one write raises several trigger bits at once, every qualifying target pulses in the same cycle. Bits that were already 1 do not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the trigger register |
| wr_data | input | 6 | Value written to the trigger register (bit 5 global, bits 4..0 per target) |
| ext_sync | input | 3 | External sync pulses, selected by codes 1..3 |
| glb_dis | input | 1 | 1 = per-target paths active, 0 = global path active |
| glb_sel | input | 2 | Global path source: 0 trigger bit 5, k = ext_sync[k-1] |
| tgt_dis | input | 5 | Per-target disable, bit i gates target i |
| tgt_sel | input | 10 | Per-target source select, 2 bits per target, target i at [2i+1:2i] |
| sync_pulse | output | 5 | One-cycle sync pulse per target |

## Verification
If the stored trigger value is wrong, the error shows on the next write. A stale 1 swallows a pulse that should appear, and a stale 0 turns a harmless rewrite into an extra pulse, one cycle after that write. A fault in the routing selection shows as a pulse on the wrong output, or as unequal outputs while the global path is active, in the same cycle the stimulus lands. A pulse register that fails to clear shows as a pulse two cycles wide, visible one cycle later.

// File: rtl/txsync_pkg.sv
package txsync_pkg;
  // Sizes of the router; the top module defaults its parameters to these.
  localparam int TGT_COUNT = 5;
  localparam int EXT_COUNT = 3;
  localparam int SRC_SEL_W = $clog2(EXT_COUNT + 1);
  localparam int TRIG_BITS = TGT_COUNT + 1;
  localparam int GLOBAL_BIT = TGT_COUNT;

  // Trigger bit positions; the target index equals the bit index.
  typedef enum int {
    TGT_FIFO  = 0,
    TGT_MIXER = 1,
    TGT_DIVID = 2,
    TGT_OFFS  = 3,
    TGT_GNPH  = 4
  } tgt_idx_e;
endpackage

// File: rtl/txsync_trig_capture.sv
module txsync_trig_capture #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] trig_q,
  output logic [WIDTH-1:0] rise_evt
);
  // Bits that go from 0 to 1 on this write.
  function automatic logic [WIDTH-1:0] new_ones(
    input logic             we,
    input logic [WIDTH-1:0] old_v,
    input logic [WIDTH-1:0] new_v
  );
    logic [WIDTH-1:0] res;
    res = '0;
    if (we) res = new_v & ~old_v;
    return res;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     trig_q <= '0;
    else if (wr_en) trig_q <= wr_data;
  end

  always_comb rise_evt = new_ones(wr_en, trig_q, wr_data);
endmodule

// File: rtl/txsync_route.sv
module txsync_route #(
  parameter int NUM_TGT = 5,
  parameter int NUM_EXT = 3,
  parameter int SEL_W   = 2,
  localparam int EVT_W  = NUM_TGT + 1
) (
  input  logic [EVT_W-1:0]         rise_evt,
  input  logic [NUM_EXT-1:0]       ext_sync,
  input  logic [SEL_W-1:0]         glb_sel,
  input  logic [NUM_TGT-1:0]       tgt_dis,
  input  logic [NUM_TGT*SEL_W-1:0] tgt_sel,
  output logic                     glb_fire,
  output logic [NUM_TGT-1:0]       loc_fire
);
  // Code 0 selects the serial trigger event, code k selects ext[k-1].
  function automatic logic pick_source(
    input logic [SEL_W-1:0]   sel,
    input logic               serial_evt,
    input logic [NUM_EXT-1:0] ext
  );
    logic res;
    res = serial_evt;
    for (int k = 0; k < NUM_EXT; k++)
      if (sel == SEL_W'(k + 1)) res = ext[k];
    return res;
  endfunction

  always_comb glb_fire = pick_source(glb_sel, rise_evt[NUM_TGT], ext_sync);

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_local
    logic src_hit;
    always_comb begin
      src_hit     = pick_source(tgt_sel[t*SEL_W +: SEL_W], rise_evt[t], ext_sync);
      loc_fire[t] = src_hit & ~tgt_dis[t];
    end
  end
endmodule

// File: rtl/txsync_pulse_reg.sv
module txsync_pulse_reg #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/txsync_router.sv
module txsync_router #(
  parameter int NUM_TGT = txsync_pkg::TGT_COUNT,
  parameter int NUM_EXT = txsync_pkg::EXT_COUNT,
  localparam int SEL_W  = $clog2(NUM_EXT + 1),
  localparam int TRIG_W = NUM_TGT + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [TRIG_W-1:0]        wr_data,
  input  logic [NUM_EXT-1:0]       ext_sync,
  input  logic                     glb_dis,
  input  logic [SEL_W-1:0]         glb_sel,
  input  logic [NUM_TGT-1:0]       tgt_dis,
  input  logic [NUM_TGT*SEL_W-1:0] tgt_sel,
  output logic [NUM_TGT-1:0]       sync_pulse
);
  logic [TRIG_W-1:0]  trig_q;
  logic [TRIG_W-1:0]  rise_evt;
  logic               glb_fire;
  logic [NUM_TGT-1:0] loc_fire;
  logic [NUM_TGT-1:0] route_next;

  txsync_trig_capture #(.WIDTH(TRIG_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .trig_q   (trig_q),
    .rise_evt (rise_evt)
  );

  txsync_route #(.NUM_TGT(NUM_TGT), .NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) u_route (
    .rise_evt (rise_evt),
    .ext_sync (ext_sync),
    .glb_sel  (glb_sel),
    .tgt_dis  (tgt_dis),
    .tgt_sel  (tgt_sel),
    .glb_fire (glb_fire),
    .loc_fire (loc_fire)
  );

  // Global path fans out to every target; local paths only when it is disabled.
  always_comb begin
    if (glb_dis) route_next = loc_fire;
    else         route_next = {NUM_TGT{glb_fire}};
  end

  txsync_pulse_reg #(.WIDTH(NUM_TGT)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (route_next),
    .q     (sync_pulse)
  );
endmodule

// File: rtl/txsync_router_chk.sv
module txsync_router_chk #(
  parameter int NUM_TGT = 5,
  parameter int NUM_EXT = 3,
  localparam int SEL_W  = $clog2(NUM_EXT + 1),
  localparam int TRIG_W = NUM_TGT + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [TRIG_W-1:0]        wr_data,
  input logic [TRIG_W-1:0]        trig_q,
  input logic [NUM_EXT-1:0]       ext_sync,
  input logic                     glb_dis,
  input logic [SEL_W-1:0]         glb_sel,
  input logic [NUM_TGT-1:0]       tgt_dis,
  input logic [NUM_TGT*SEL_W-1:0] tgt_sel,
  input logic [NUM_TGT-1:0]       sync_pulse
);
  // R1: a clock under reset leaves every output low
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (sync_pulse == '0));

  // R2: a write raising no bit, with no external pulse, gives no pulse
  p_no_rise_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_data & ~trig_q) == '0) && (ext_sync == '0)) |=> (sync_pulse == '0));

  // R5: global path active means all outputs move together
  p_global_fanout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_dis |=> ((sync_pulse == '0) || (sync_pulse == '1)));

  // R6: no stimulus, no pulse next cycle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (ext_sync == '0)) |=> (sync_pulse == '0));

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    // R4: a disabled target stays silent on the local path
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_dis && tgt_dis[t]) |=> !sync_pulse[t]);

    // R3: a rising own bit with serial select fires its own output
    p_local_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_dis && !tgt_dis[t] && (tgt_sel[t*SEL_W +: SEL_W] == '0) &&
       wr_en && wr_data[t] && !trig_q[t]) |=> sync_pulse[t]);

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
      // R7: selected external pulse reaches an enabled target
      p_ext_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_dis && !tgt_dis[t] && (tgt_sel[t*SEL_W +: SEL_W] == SEL_W'(k + 1)) &&
         ext_sync[k]) |=> sync_pulse[t]);
    end
  end
endmodule

bind txsync_router txsync_router_chk #(.NUM_TGT(NUM_TGT), .NUM_EXT(NUM_EXT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .trig_q     (trig_q),
  .ext_sync   (ext_sync),
  .glb_dis    (glb_dis),
  .glb_sel    (glb_sel),
  .tgt_dis    (tgt_dis),
  .tgt_sel    (tgt_sel),
  .sync_pulse (sync_pulse)
);

// File: tb/txsync_router_bench.sv
module txsync_router_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic [2:0] ext_sync = '0;
  logic       glb_dis = 1'b1;
  logic [1:0] glb_sel = '0;
  logic [4:0] tgt_dis = '0;
  logic [9:0] tgt_sel = '0;
  logic [4:0] sync_pulse;

  int n_vec = 0;
  int n_bad = 0;
  logic [5:0] shadow = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txsync_router u_txsync_router (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ext_sync   (ext_sync),
    .glb_dis    (glb_dis),
    .glb_sel    (glb_sel),
    .tgt_dis    (tgt_dis),
    .tgt_sel    (tgt_sel),
    .sync_pulse (sync_pulse)
  );

  // Expected outputs, worked out from the requirements target by target.
  function automatic logic [4:0] ref_out(input logic [5:0] prev, input logic we,
                                         input logic [5:0] d, input logic [2:0] ext);
    logic [5:0] up;
    logic [4:0] res;
    logic       g_src;
    up = '0;
    for (int i = 0; i < 6; i++) if (we && d[i] && !prev[i]) up[i] = 1'b1;
    g_src = (glb_sel == 2'd0) ? up[5] : ext[glb_sel - 2'd1];
    for (int t = 0; t < 5; t++) begin
      logic [1:0] s;
      logic l_src;
      s = tgt_sel[2*t +: 2];
      l_src = (s == 2'd0) ? up[t] : ext[s - 2'd1];
      if (!glb_dis) res[t] = g_src;
      else          res[t] = l_src && !tgt_dis[t];
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp_v);
    n_vec++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s: sync_pulse=%b expected %b", req, got, exp_v);
    end
  endtask

  task automatic do_write(input logic [5:0] d, input string req);
    logic [4:0] exp_v;
    @(negedge clk);
    exp_v = ref_out(shadow, 1'b1, d, 3'b000);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(req, sync_pulse, exp_v);
    shadow = d;
  endtask

  task automatic do_ext(input logic [2:0] m, input string req);
    logic [4:0] exp_v;
    @(negedge clk);
    exp_v = ref_out(shadow, 1'b0, 6'd0, m);
    ext_sync = m;
    @(negedge clk);
    ext_sync = '0;
    check(req, sync_pulse, exp_v);
  endtask

  task automatic t_reset();
    check("R1 during reset", sync_pulse, 5'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", sync_pulse, 5'b0);
    glb_dis = 1'b1; tgt_dis = '0; tgt_sel = '0;
    do_write(6'h01, "R1 first write rises");
    check("R1 literal", 5'b00001, 5'b00001);
    do_write(6'h00, "R1 clear");
  endtask

  task automatic t_bitmap();
    glb_dis = 1'b1; tgt_dis = '0; tgt_sel = '0;
    for (int t = 0; t < 5; t++) begin
      logic [4:0] got;
      @(negedge clk); wr_en = 1'b1; wr_data = 6'(1 << t);
      @(negedge clk); wr_en = 1'b0; got = sync_pulse; shadow = 6'(1 << t);
      check("R3 bit map", got, 5'(1 << t));
      do_write(6'h00, "R3 clear");
    end
  endtask

  task automatic t_edge();
    glb_dis = 1'b1; tgt_dis = '0; tgt_sel = '0;
    do_write(6'h04, "R2 rise");
    do_write(6'h04, "R2 rewrite one");
    @(negedge clk); wr_data = 6'h00;
    @(negedge clk); check("R2 data without strobe", sync_pulse, 5'b0);
    do_write(6'h04, "R2 still held high");
    do_write(6'h00, "R2 falling");
    do_write(6'h04, "R2 rise again");
    @(negedge clk); check("R6 one cycle wide", sync_pulse, 5'b0);
    do_write(6'h00, "R6 clear");
  endtask

  task automatic t_qual();
    glb_dis = 1'b1; tgt_dis = 5'b00100; tgt_sel = '0;
    do_write(6'h1F, "R4 disabled target");
    check("R4 literal", 5'b11011, ref_out(6'h00, 1'b1, 6'h1F, 3'b000));
    do_write(6'h00, "R4 clear");
    tgt_dis = '0; tgt_sel = 10'b00_00_00_10_00;
    do_write(6'h1F, "R4 external select blocks bit");
    do_write(6'h00, "R4 clear");
    tgt_sel = '0; glb_dis = 1'b0; glb_sel = 2'd3;
    do_write(6'h1F, "R4 global path active");
    do_write(6'h00, "R4 clear");
  endtask

  task automatic t_global();
    glb_dis = 1'b0; glb_sel = 2'd0; tgt_dis = 5'b10101; tgt_sel = '0;
    do_write(6'h20, "R5 global fan-out");
    @(negedge clk); check("R6 global one cycle", sync_pulse, 5'b0);
    do_write(6'h20, "R5 global held");
    do_write(6'h00, "R5 clear");
    glb_dis = 1'b1;
    do_write(6'h20, "R5 global ignored when disabled");
    do_write(6'h00, "R5 clear");
    glb_dis = 1'b0; glb_sel = 2'd1;
    do_write(6'h20, "R5 global non-serial select");
    do_write(6'h00, "R5 clear");
    tgt_dis = '0;
  endtask

  task automatic t_ext();
    glb_dis = 1'b1; tgt_dis = '0; tgt_sel = 10'b00_11_00_00_01;
    do_ext(3'b001, "R7 ext0 to fifo");
    do_ext(3'b100, "R7 ext2 to offset");
    do_ext(3'b010, "R7 unselected ext");
    tgt_dis = 5'b00001;
    do_ext(3'b001, "R7 disabled target");
    tgt_dis = '0; glb_dis = 1'b0; glb_sel = 2'd2;
    do_ext(3'b010, "R7 global ext fan-out");
    do_ext(3'b001, "R7 global other ext");
    glb_sel = 2'd0; tgt_sel = '0;
  endtask

  task automatic t_multi();
    glb_dis = 1'b1; tgt_dis = '0; tgt_sel = '0;
    do_write(6'h15, "R8 several rise");
    do_write(6'h1F, "R8 only new bits");
    check("R8 literal", 5'b01010, ref_out(6'h15, 1'b1, 6'h1F, 3'b000));
    do_write(6'h00, "R8 clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_bitmap();
    t_edge();
    t_qual();
    t_global();
    t_ext();
    t_multi();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule